// File: doc/BRIEF.md
# Interrupt Control and Skip-Test Unit

This unit sits beside the decoder of a small 4-bit controller. It keeps the global interrupt enable, three software-visible control registers and one pending-request flag for each of three interrupt sources: an external input and two timers. The decoder hands it one-cycle strobes for each instruction it serves. The unit answers with a skip pulse that tells the sequencer to drop the next instruction.

Each flag-test instruction looks at one request flag. It acts only while that source is masked off by its gate bit in the source-gate register. In that case, a pending flag causes a skip and is consumed. While the gate bit is set, the test does nothing at all. The pin-test instruction compares the level of the external interrupt pin against a polarity bit and skips on a match.

The control registers are loaded from the accumulator bus and read back onto a 4-bit read bus. Request flags are raised by single-cycle pulses from their sources. A raise always beats a clear that falls in the same cycle.

Top module: `irq_skip_ctl`

## Requirements
- R1: A one-cycle `op_ei` strobe makes `int_en` 1 from the next cycle on, and `op_di` makes it 0. If both strobes come in the same cycle, `op_di` wins.
- R2: With bit 0 of the source-gate register at 0, `op_tst_ext` on a pending external flag gives a skip and clears that flag. On a clear flag it gives no skip.
- R3: With bit 0 of the source-gate register at 1, `op_tst_ext` gives no skip and leaves the external flag unchanged. A later test with the bit at 0 still sees the pending flag.
- R4: `op_tst_t1` behaves the same way on the timer-1 flag, gated by bit 2 of the source-gate register. `op_tst_t2` behaves the same way on the timer-2 flag, gated by bit 3.
- R5: `op_tst_pin` skips when `int_pin` is 0 while bit 2 of the pin-control register is 0. It skips when `int_pin` is 1 while that bit is 1. Otherwise it does not skip.
- R6: `wr_en` loads `acc_in` into the register picked by `reg_sel`: 0 selects the source-gate register, 1 the auxiliary register, 2 the pin-control register, and 3 writes nothing. `rd_data` shows the selected register combinationally while `rd_en` is 1. It is 0 when `reg_sel` is 3 or `rd_en` is 0.
- R7: While `rst_n` is low, and after reset, every control register, request flag, `int_en` and `skip` is 0.
- R8: When a set pulse and a consuming test of the same flag fall in the same cycle, the test still skips and the flag stays 1.
- R9: `skip` is high for exactly the one cycle after a test strobe whose condition holds. It is never high in a cycle that does not follow such a strobe.
- R10: A set pulse raises its flag whatever the gate bits hold. The flag then stays 1 until a consuming test clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_ei | input | 1 | Enable-interrupts strobe |
| op_di | input | 1 | Disable-interrupts strobe |
| op_tst_ext | input | 1 | External flag test strobe |
| op_tst_t1 | input | 1 | Timer-1 flag test strobe |
| op_tst_t2 | input | 1 | Timer-2 flag test strobe |
| op_tst_pin | input | 1 | Pin-level test strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read select |
| reg_sel | input | 2 | Register select (0 gate, 1 aux, 2 pin control) |
| acc_in | input | 4 | Accumulator write data |
| int_pin | input | 1 | External interrupt pin level |
| set_ext | input | 1 | External request set pulse |
| set_t1 | input | 1 | Timer-1 request set pulse |
| set_t2 | input | 1 | Timer-2 request set pulse |
| skip | output | 1 | Skip-next-instruction pulse |
| rd_data | output | 4 | Register read data |
| int_en | output | 1 | Interrupt enable flag |

## Verification
The skip path is exercised in four ways:
- A pending flag is tested with its gate bit clear and with it set. This separates a consuming test from a no-op.
- The same flag is tested twice in a row. The second, silent test shows that the first one cleared it.
- The pin test runs with both polarity settings against both pin levels. This exposes an inverted or ignored polarity bit.
- Set pulses are made to coincide with tests. Long random runs then mix overlapping strobes, pin changes and register writes, so that a wrong gate-bit position or a lost flag shows up as a mismatch in the skip sequence.

// File: rtl/irq_skip_pkg.sv
package irq_skip_pkg;
  localparam int DW    = 4;
  localparam int N_SRC = 3;
  localparam int POL_BIT = 2;

  typedef enum logic [1:0] {
    SEL_GATE = 2'd0,
    SEL_AUX  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // bit of the source-gate register that masks source s (0 ext, 1 t1, 2 t2)
  function automatic int gate_bit(int s);
    case (s)
      0:       return 0;
      1:       return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/irq_req_flag.sv
module irq_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic test_i,
  input  logic gate_i,
  output logic flag_o,
  output logic hit_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    hit_o   = test_i & ~gate_i & flag_q;
    flag_en = set_i | hit_o;
    flag_d  = set_i | (flag_q & ~hit_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_skip_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_ei,
  input  logic          op_di,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] gate_o,
  output logic [DW-1:0] pin_cfg_o,
  output logic          int_en_o,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] gate_q, aux_q, pin_q;
  logic          en_q, en_d, en_ce;
  logic          gate_ce, aux_ce, pin_ce;

  always_comb begin
    gate_ce = wr_en & (reg_sel == SEL_GATE);
    aux_ce  = wr_en & (reg_sel == SEL_AUX);
    pin_ce  = wr_en & (reg_sel == SEL_PIN);
    en_ce   = op_ei | op_di;
    en_d    = ~op_di;
    rd_data = '0;
    if (rd_en) begin
      case (reg_sel)
        SEL_GATE: rd_data = gate_q;
        SEL_AUX:  rd_data = aux_q;
        SEL_PIN:  rd_data = pin_q;
        default:  rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      aux_q  <= '0;
      pin_q  <= '0;
      en_q   <= 1'b0;
    end else begin
      if (gate_ce) gate_q <= wdata;
      if (aux_ce)  aux_q  <= wdata;
      if (pin_ce)  pin_q  <= wdata;
      if (en_ce)   en_q   <= en_d;
    end
  end

  assign gate_o    = gate_q;
  assign pin_cfg_o = pin_q;
  assign int_en_o  = en_q;
endmodule

// File: rtl/irq_skip_ctl.sv
module irq_skip_ctl
  import irq_skip_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_ei,
  input  logic          op_di,
  input  logic          op_tst_ext,
  input  logic          op_tst_t1,
  input  logic          op_tst_t2,
  input  logic          op_tst_pin,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] acc_in,
  input  logic          int_pin,
  input  logic          set_ext,
  input  logic          set_t1,
  input  logic          set_t2,
  output logic          skip,
  output logic [DW-1:0] rd_data,
  output logic          int_en
);
  logic             srst_n;
  logic [DW-1:0]    gate_q, pin_cfg_q;
  logic [N_SRC-1:0] set_vec, tst_vec, flag_q, hit_vec;
  logic             pin_hit, skip_d, skip_q;

  assign set_vec = {set_t2, set_t1, set_ext};
  assign tst_vec = {op_tst_t2, op_tst_t1, op_tst_ext};

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  irq_ctl_regs u_regs (
    .clk(clk), .rst_n(srst_n), .op_ei(op_ei), .op_di(op_di),
    .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel), .wdata(acc_in),
    .gate_o(gate_q), .pin_cfg_o(pin_cfg_q), .int_en_o(int_en),
    .rd_data(rd_data)
  );

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    irq_req_flag u_flag (
      .clk(clk), .rst_n(srst_n), .set_i(set_vec[s]), .test_i(tst_vec[s]),
      .gate_i(gate_q[gate_bit(s)]), .flag_o(flag_q[s]), .hit_o(hit_vec[s])
    );
  end

  always_comb begin
    pin_hit = op_tst_pin & (int_pin == pin_cfg_q[POL_BIT]);
    skip_d  = (|hit_vec) | pin_hit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) skip_q <= 1'b0;
    else         skip_q <= skip_d;
  end

  assign skip = skip_q;
endmodule

// File: rtl/irq_skip_chk.sv
module irq_skip_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       op_ei,
  input logic       op_di,
  input logic       op_tst_ext,
  input logic       op_tst_t1,
  input logic       op_tst_t2,
  input logic       op_tst_pin,
  input logic       int_pin,
  input logic [2:0] set_vec,
  input logic [3:0] gate,
  input logic [3:0] pin_cfg,
  input logic [2:0] flags,
  input logic       skip,
  input logic       int_en
);
  AST_EN_RISE: assert property (@(posedge clk) disable iff (!srst_n)
    (op_ei && !op_di) |=> int_en); // R1
  AST_EN_FALL: assert property (@(posedge clk) disable iff (!srst_n)
    op_di |=> !int_en); // R1
  AST_EXT_CONSUME: assert property (@(posedge clk) disable iff (!srst_n)
    (op_tst_ext && !gate[0] && flags[0] && !set_vec[0]) |=> (!flags[0] && skip)); // R2
  AST_EXT_GATED_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    (op_tst_ext && gate[0] && !set_vec[0]) |=> (flags[0] == $past(flags[0]))); // R3
  AST_T1_CONSUME: assert property (@(posedge clk) disable iff (!srst_n)
    (op_tst_t1 && !gate[2] && flags[1] && !set_vec[1]) |=> (!flags[1] && skip)); // R4
  AST_T2_CONSUME: assert property (@(posedge clk) disable iff (!srst_n)
    (op_tst_t2 && !gate[3] && flags[2] && !set_vec[2]) |=> (!flags[2] && skip)); // R4
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!srst_n)
    (op_tst_pin && !op_tst_ext && !op_tst_t1 && !op_tst_t2)
      |=> (skip == ($past(int_pin) == $past(pin_cfg[2])))); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!srst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R8
  AST_SKIP_CAUSE: assert property (@(posedge clk) disable iff (!srst_n)
    skip |-> $past(op_tst_ext || op_tst_t1 || op_tst_t2 || op_tst_pin)); // R9
endmodule

bind irq_skip_ctl irq_skip_chk u_chk (
  .clk(clk), .srst_n(srst_n), .op_ei(op_ei), .op_di(op_di),
  .op_tst_ext(op_tst_ext), .op_tst_t1(op_tst_t1), .op_tst_t2(op_tst_t2),
  .op_tst_pin(op_tst_pin), .int_pin(int_pin), .set_vec(set_vec),
  .gate(gate_q), .pin_cfg(pin_cfg_q), .flags(flag_q), .skip(skip),
  .int_en(int_en)
);

// File: tb/irq_skip_ctl_tb.sv
module irq_skip_ctl_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       op_ei, op_di, op_tst_ext, op_tst_t1, op_tst_t2, op_tst_pin;
  logic       wr_en, rd_en, int_pin, set_ext, set_t1, set_t2;
  logic [1:0] reg_sel;
  logic [3:0] acc_in, rd_data;
  logic       skip, int_en;

  int n_chk = 0;
  int n_fail = 0;

  // bench model, from the requirements
  logic [3:0] m_gate, m_aux, m_pin;
  logic [2:0] m_flag;
  logic       m_en;

  irq_skip_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .op_ei(op_ei), .op_di(op_di),
    .op_tst_ext(op_tst_ext), .op_tst_t1(op_tst_t1), .op_tst_t2(op_tst_t2),
    .op_tst_pin(op_tst_pin), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .acc_in(acc_in), .int_pin(int_pin), .set_ext(set_ext), .set_t1(set_t1),
    .set_t2(set_t2), .skip(skip), .rd_data(rd_data), .int_en(int_en)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_read(logic en, logic [1:0] sel);
    if (!en) return 4'h0;
    case (sel)
      2'd0: return m_gate;
      2'd1: return m_aux;
      2'd2: return m_pin;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [2:0] exp_hits();
    logic [2:0] h;
    h[0] = op_tst_ext & ~m_gate[0] & m_flag[0];
    h[1] = op_tst_t1  & ~m_gate[2] & m_flag[1];
    h[2] = op_tst_t2  & ~m_gate[3] & m_flag[2];
    return h;
  endfunction

  task automatic idle();
    op_ei = 0; op_di = 0; op_tst_ext = 0; op_tst_t1 = 0; op_tst_t2 = 0;
    op_tst_pin = 0; wr_en = 0; rd_en = 0; reg_sel = 0; acc_in = 0;
    set_ext = 0; set_t1 = 0; set_t2 = 0;
  endtask

  // called at a falling edge with inputs already driven
  task automatic step(string req);
    logic [2:0] h;
    logic       e_skip;
    #1;
    chk({req, " R6 rd_data"}, rd_data, exp_read(rd_en, reg_sel));
    h = exp_hits();
    e_skip = (|h) | (op_tst_pin & (int_pin == m_pin[2]));
    @(posedge clk);
    m_flag = {set_t2, set_t1, set_ext} | (m_flag & ~h);
    if (op_di) m_en = 1'b0;
    else if (op_ei) m_en = 1'b1;
    if (wr_en) begin
      case (reg_sel)
        2'd0: m_gate = acc_in;
        2'd1: m_aux  = acc_in;
        2'd2: m_pin  = acc_in;
        default: ;
      endcase
    end
    @(negedge clk);
    chk({req, " R9 skip"}, {3'b0, skip}, {3'b0, e_skip});
    chk({req, " R1 int_en"}, {3'b0, int_en}, {3'b0, m_en});
    idle();
  endtask

  task automatic wr(logic [1:0] sel, logic [3:0] v);
    wr_en = 1; reg_sel = sel; acc_in = v; step("R6 write");
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(); int_pin = 1;
    m_gate = 0; m_aux = 0; m_pin = 0; m_flag = 0; m_en = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk("R7 skip in reset", {3'b0, skip}, 4'h0);
    chk("R7 int_en in reset", {3'b0, int_en}, 4'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rd_en = 1; reg_sel = s[1:0]; step("R7 reset read");
    end
    // flags are 0 after reset: tests with gates open do not skip
    op_tst_ext = 1; step("R7 ext flag");
    op_tst_t1 = 1; step("R7 t1 flag");
    op_tst_t2 = 1; step("R7 t2 flag");

    // R1
    op_ei = 1; step("R1 enable");
    op_ei = 1; op_di = 1; step("R1 both, disable wins");
    op_ei = 1; step("R1 enable again");
    op_di = 1; step("R1 disable");

    // R2
    set_ext = 1; step("R10 raise ext");
    op_tst_ext = 1; step("R2 ext consume");
    op_tst_ext = 1; step("R2 ext already cleared");

    // R3
    wr(2'd0, 4'b0001);
    set_ext = 1; step("R10 raise ext gated");
    op_tst_ext = 1; step("R3 gated nop");
    wr(2'd0, 4'b0000);
    op_tst_ext = 1; step("R3 flag kept");

    // R4: wrong gate bits must not mask
    wr(2'd0, 4'b0011);
    set_t1 = 1; set_t2 = 1; step("R10 raise timers");
    op_tst_t1 = 1; step("R4 t1 open via bit2");
    wr(2'd0, 4'b1100);
    op_tst_t2 = 1; step("R4 t2 gated by bit3");
    wr(2'd0, 4'b0100);
    op_tst_t2 = 1; step("R4 t2 open");
    op_tst_t2 = 1; step("R4 t2 cleared");

    // R8
    wr(2'd0, 4'b0000);
    set_ext = 1; step("R10 raise ext");
    set_ext = 1; op_tst_ext = 1; step("R8 set and test");
    op_tst_ext = 1; step("R8 flag survived");

    // R5
    for (int p = 0; p < 2; p++) begin
      wr(2'd2, p[0] ? 4'b0100 : 4'b1011);
      for (int l = 0; l < 2; l++) begin
        int_pin = l[0]; op_tst_pin = 1; step("R5 pin polarity");
      end
    end

    // R6
    wr(2'd1, 4'hA);
    wr(2'd3, 4'h5);
    for (int s = 0; s < 4; s++) begin
      rd_en = 1; reg_sel = s[1:0]; step("R6 readback");
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      op_ei      = ($urandom % 8) == 0;
      op_di      = ($urandom % 8) == 0;
      op_tst_ext = ($urandom % 5) == 0;
      op_tst_t1  = ($urandom % 5) == 0;
      op_tst_t2  = ($urandom % 5) == 0;
      op_tst_pin = ($urandom % 6) == 0;
      set_ext    = ($urandom % 4) == 0;
      set_t1     = ($urandom % 4) == 0;
      set_t2     = ($urandom % 4) == 0;
      wr_en      = ($urandom % 7) == 0;
      rd_en      = ($urandom % 2) == 0;
      reg_sel    = 2'($urandom);
      acc_in     = 4'($urandom);
      int_pin    = 1'($urandom);
      step("R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule